// File: doc/BRIEF.md
# DMA Cycle Continuation Controller

This block sits beside a DMA engine that runs transfers on a PCI-style bus. For each transfer cycle it produces the active-low byte-enable vector that matches the width of the device's channel. When the target signals that it is ready, the block decides whether the engine may start another cycle or must end the transfer sequence.

A sequence ends in either of two cases. The first is a terminal count on a channel that is not set to reload itself. The second is the device withdrawing its request early enough. The block keeps a short shift history of the sampled request line. At the target-ready edge it looks at the sample taken a fixed number of clocks earlier. A request dropped later than that window still lets one more cycle run. On a terminal count with autoinitialize set, the block issues a reload pulse and lets the sequence go on. The decision is registered and is valid for one clock.

Top module: `dma_cont_ctrl`

## Requirements
- R1: While `cyc_active` is low, `be_n` is 4'b1111.
- R2: In an active read (`xfer_type` 0) or write (`xfer_type` 1) cycle on channels 0 to 3, `be_n` is 4'b1110. Bit 0 is the lowest byte lane.
- R3: In an active read or write cycle on channels 5 to 7, `be_n` is 4'b1100.
- R4: In an active cycle on the reserved channel 4, `be_n` is 4'b1111.
- R5: In an active verify cycle (`xfer_type` 2), `be_n` is 4'b1111 on every channel.
- R6: Take a rising clock edge that samples `trdy` and `cyc_active` both high. After that edge, `dec_valid` is high for exactly one clock. It stays low otherwise.
- R7: A decision made with `tc` high and `auto_init` low has `dec_continue` low and `reload` low.
- R8: A decision made with `tc` and `auto_init` both high, and with no qualifying withdrawal, has `dec_continue` high and `reload` high.
- R9: Suppose `dreq_n` was sampled high at the edge 7 clocks before the edge that samples `trdy`. Then the decision has `dec_continue` low.
- R10: Suppose `dreq_n` was first sampled high 6 or fewer clocks before the `trdy` edge, and `tc` is low. Then the decision has `dec_continue` high, allowing one more cycle.
- R11: A `trdy` pulse while `cyc_active` is low produces no decision: `dec_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_active | input | 1 | A DMA transfer cycle is in progress |
| chan | input | 3 | Channel number of the current cycle |
| xfer_type | input | 2 | 0 read, 1 write, 2 verify |
| tc | input | 1 | Terminal count reached on this cycle |
| auto_init | input | 1 | Channel reloads itself at terminal count |
| dreq_n | input | 1 | Active-low device request |
| trdy | input | 1 | Target-ready strobe, active high |
| be_n | output | 4 | Active-low byte enables |
| dec_valid | output | 1 | Decision valid, one clock |
| dec_continue | output | 1 | 1: another cycle may run; 0: terminate |
| reload | output | 1 | Address/count reload pulse, with the decision |

## Verification
A corrupted request history shows at the ports as a wrong `dec_continue`. This appears on the first decision whose lookback window covers the bad entry, and at most 7 clocks after the fault. The bench moves the withdrawal edge across the 6- and 7-clock boundary to expose off-by-one tap errors. A wrong decision register shows in the clock right after the `trdy` edge, either as a missing or extra `dec_valid` or as a wrong `reload`. Byte-enable faults are combinational and show within the same cycle as the channel change.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;
  typedef enum logic [1:0] {
    XF_READ   = 2'd0,
    XF_WRITE  = 2'd1,
    XF_VERIFY = 2'd2
  } xfer_e;

  localparam logic [3:0] BE_NONE   = 4'b1111;
  localparam logic [3:0] BE_NARROW = 4'b1110;
  localparam logic [3:0] BE_WIDE   = 4'b1100;
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dma_be_gen.sv
module dma_be_gen
  import dma_cc_pkg::*;
#(
  parameter int CH_W        = 3,
  parameter int NARROW_LAST = 3,
  parameter int RSVD_CH     = 4
) (
  input  logic            cyc_active,
  input  logic [CH_W-1:0] chan,
  input  logic [1:0]      xfer_type,
  output logic [3:0]      be_n
);
  localparam int WIDE_FIRST = RSVD_CH + 1;

  always_comb begin
    be_n = BE_NONE;
    if (cyc_active && (xfer_type != XF_VERIFY)) begin
      if (int'(chan) <= NARROW_LAST)     be_n = BE_NARROW;
      else if (int'(chan) >= WIDE_FIRST) be_n = BE_WIDE;
      else                               be_n = BE_NONE;
    end
  end

  always_comb begin
    if (cyc_active && xfer_type == XF_VERIFY)
      p_verify_be_r5: assert (be_n == BE_NONE);
  end
endmodule

// File: rtl/dma_req_hist.sv
module dma_req_hist #(
  parameter int LOOKBACK = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq_n,
  output logic withdrawn_early
);
  logic [LOOKBACK-1:0] hist_q, hist_d;

  always_comb hist_d = {hist_q[LOOKBACK-2:0], dreq_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  // Tap at LOOKBACK-1: the sample taken LOOKBACK edges before the current edge.
  assign withdrawn_early = hist_q[LOOKBACK-1];
endmodule

// File: rtl/dma_cont_decide.sv
module dma_cont_decide (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_active,
  input  logic trdy,
  input  logic tc,
  input  logic auto_init,
  input  logic withdrawn_early,
  output logic dec_valid,
  output logic dec_continue,
  output logic reload
);
  logic fire;
  logic valid_d, cont_d, reload_d;

  always_comb begin
    fire     = trdy && cyc_active;
    valid_d  = fire;
    cont_d   = dec_continue;
    reload_d = 1'b0;
    if (fire) begin
      cont_d   = !((tc && !auto_init) || withdrawn_early);
      reload_d = tc && auto_init;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid    <= 1'b0;
      dec_continue <= 1'b0;
      reload       <= 1'b0;
    end else begin
      dec_valid <= valid_d;
      reload    <= reload_d;
      if (fire) dec_continue <= cont_d;
    end
  end

  p_tc_term_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy && cyc_active && tc && !auto_init) |=> (dec_valid && !dec_continue && !reload));

  p_reload_with_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> dec_valid);
endmodule

// File: rtl/dma_cont_ctrl.sv
module dma_cont_ctrl #(
  parameter int CH_W     = 3,
  parameter int LOOKBACK = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_active,
  input  logic [CH_W-1:0] chan,
  input  logic [1:0]      xfer_type,
  input  logic            tc,
  input  logic            auto_init,
  input  logic            dreq_n,
  input  logic            trdy,
  output logic [3:0]      be_n,
  output logic            dec_valid,
  output logic            dec_continue,
  output logic            reload
);
  logic rst_n_i;
  logic withdrawn_early;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  dma_be_gen #(.CH_W(CH_W)) u_be (
    .cyc_active(cyc_active), .chan(chan), .xfer_type(xfer_type), .be_n(be_n)
  );

  dma_req_hist #(.LOOKBACK(LOOKBACK)) u_hist (
    .clk(clk), .rst_n(rst_n_i), .dreq_n(dreq_n), .withdrawn_early(withdrawn_early)
  );

  dma_cont_decide u_dec (
    .clk(clk), .rst_n(rst_n_i), .cyc_active(cyc_active), .trdy(trdy),
    .tc(tc), .auto_init(auto_init), .withdrawn_early(withdrawn_early),
    .dec_valid(dec_valid), .dec_continue(dec_continue), .reload(reload)
  );

  always_comb begin
    if (!cyc_active) p_idle_be_r1: assert (be_n == 4'b1111);
  end

  p_dec_valid_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (trdy && cyc_active) |=> dec_valid);

  p_no_dec_r11: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(trdy && cyc_active) |=> !dec_valid);
endmodule

// File: tb/dma_cont_ctrl_tb.sv
module dma_cont_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_active, tc, auto_init, dreq_n, trdy;
  logic [2:0] chan;
  logic [1:0] xfer_type;
  logic [3:0] be_n;
  logic       dec_valid, dec_continue, reload;

  int checks = 0;
  int fails  = 0;
  logic [1:0] exp_q[$];   // {continue, reload}
  string      tag_q[$];

  always #4 clk = ~clk;   // 125 MHz

  dma_cont_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_active(cyc_active), .chan(chan),
    .xfer_type(xfer_type), .tc(tc), .auto_init(auto_init), .dreq_n(dreq_n),
    .trdy(trdy), .be_n(be_n), .dec_valid(dec_valid),
    .dec_continue(dec_continue), .reload(reload)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Monitor: pops one expectation per decision.
  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected dec_valid", 4'd1, 4'd0);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {2'b00, dec_continue, reload}, {2'b00, e});
      end
    end
  end

  // Driver: one cycle; lead = clocks before trdy edge at which dreq_n is first sampled high (0 = never).
  task automatic run_cycle(input string tag, input logic [2:0] ch, input logic [1:0] ty,
                           input logic t, input logic ai, input int lead);
    logic wd;
    @(negedge clk);
    cyc_active = 1'b1; chan = ch; xfer_type = ty; tc = 1'b0; auto_init = ai; dreq_n = 1'b0;
    for (int k = 10; k >= 1; k--) begin
      @(negedge clk);
      dreq_n = (lead != 0) && (k <= lead);
    end
    @(negedge clk);
    trdy = 1'b1; tc = t;
    wd = (lead >= 7);
    exp_q.push_back({!((t && !ai) || wd), t && ai});
    tag_q.push_back(tag);
    @(negedge clk);
    trdy = 1'b0; tc = 1'b0; dreq_n = 1'b0;
    @(negedge clk);
    check({tag, " queue drained"}, 4'(exp_q.size()), 4'd0);
  endtask

  initial begin
    fork
      begin
        #1000000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
      begin
        rst_n = 1'b0; cyc_active = 1'b0; chan = '0; xfer_type = 2'd0;
        tc = 1'b0; auto_init = 1'b0; dreq_n = 1'b0; trdy = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 reset dec_valid", {3'b0, dec_valid}, 4'd0);
        check("R1 reset be_n", be_n, 4'b1111);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Byte enables (R1-style checks each written out)
        for (int c = 0; c < 8; c++) begin
          cyc_active = 1'b1; chan = 3'(c); xfer_type = 2'd1; #1;
          if (c <= 3)      check("R2 narrow be", be_n, 4'b1110);
          else if (c == 4) check("R4 reserved be", be_n, 4'b1111);
          else             check("R3 wide be", be_n, 4'b1100);
          xfer_type = 2'd0; #1;
          if (c <= 3)      check("R2 narrow read be", be_n, 4'b1110);
          else if (c >= 5) check("R3 wide read be", be_n, 4'b1100);
          xfer_type = 2'd2; #1;
          check("R5 verify be", be_n, 4'b1111);
          cyc_active = 1'b0; #1;
          check("R1 idle be", be_n, 4'b1111);
        end

        run_cycle("R7 tc terminate", 3'd1, 2'd1, 1'b1, 1'b0, 0);
        run_cycle("R8 tc autoinit reload", 3'd6, 2'd0, 1'b1, 1'b1, 0);
        run_cycle("R9 early withdraw 7", 3'd2, 2'd0, 1'b0, 1'b0, 7);
        run_cycle("R9 early withdraw 9", 3'd5, 2'd1, 1'b0, 1'b0, 9);
        run_cycle("R10 late withdraw 6", 3'd3, 2'd1, 1'b0, 1'b0, 6);
        run_cycle("R10 late withdraw 2", 3'd7, 2'd0, 1'b0, 1'b0, 2);
        run_cycle("R10 held request", 3'd0, 2'd2, 1'b0, 1'b1, 0);
        run_cycle("R9 withdraw with autoinit tc", 3'd5, 2'd0, 1'b1, 1'b1, 8);

        // R11: trdy with no active cycle
        @(negedge clk);
        cyc_active = 1'b0; trdy = 1'b1;
        @(negedge clk);
        trdy = 1'b0;
        check("R11 idle trdy dec_valid", {3'b0, dec_valid}, 4'd0);
        @(negedge clk);
        check("R6 one-clock dec_valid", {3'b0, dec_valid}, 4'd0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule